// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the two-wire PHY management bus. Software programs a control register with an MDC divisor and an MDIO hold time. It then writes one 32-bit frame word into the data register. That single write starts a transaction. The block sends a preamble of ones, then shifts the frame word out most significant bit first on MDIO, and generates MDC from the core clock.

Both Clause 22 and Clause 45 accesses use the same mechanism. The start and opcode fields are sent exactly as software wrote them. A Clause 45 access is made of two frames: first an address frame that carries the register address in its data field, then the read or write frame. For a read, the master releases MDIO for the turnaround and data bits and captures the sixteen bits the PHY returns. It then places them in the low half of the data register.

When a frame ends, a sticky event bit is raised, and software clears it by writing a one. While a frame is running, a busy status can be read and further frame writes are dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads divisor 63 in bits 7:0 and hold 5 in bits 10:8. The event register (word address 2) reads zero. MDC is low and MDIO is released (mdio_oe_o low).
- R2: A write to the data register (word address 1) while idle launches one frame. The frame is 32 one bits followed by the 32 bits of the written word, bit 31 first, 64 MDC rising edges in total.
- R3: The MDC period is 2*max(div,2) core cycles, where div is control bits 7:0. MDC stays low while no frame is in progress.
- R4: MDIO changes hold_eff+1 core cycles after an MDC falling edge, where hold_eff = min(hold, max(div,2)-2) and hold is control bits 10:8. MDIO and its enable are stable while MDC is high, and the input is sampled at the MDC rising edge.
- R5: When bit 29 of the frame word is 1 (a read opcode), the master stops driving MDIO from the first turnaround bit (frame bit 17) to the end of the frame. For any other frame it drives every bit.
- R6: After a read frame completes, data register bits 15:0 hold the 16 bits the PHY returned, first-received bit in bit 15. Bits 31:16 keep the written word.
- R7: Completion sets event register bit 0 in the same cycle busy drops. The bit stays set until a write to the event register with bit 0 = 1. Writing 0 has no effect, and a completion in the same cycle as a clear leaves the bit set.
- R8: Event register bit 1 reads 1 from the cycle after the launching write until completion.
- R9: A data register write while busy is ignored. The register content and the running frame are unchanged, and no extra frame follows.
- R10: Clause 22 codes (start 01, opcode 01 write, 10 read) and Clause 45 codes (start 00, opcode 00 address, 01 write, 11 read) are carried in frame bits 31:28. A Clause 45 address frame followed by a read or a write frame behaves by R2, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle per write |
| we_i | input | 1 | Write enable qualifying req_i |
| addr_i | input | 2 | Word address: 0 control, 1 data, 2 event |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The checks assume that the control register is not rewritten while a frame is in progress. If it were, the MDC period could change mid-frame, and the property that MDIO is steady while MDC is high could fail. The checks also assume a PHY that changes its data only after an MDC falling edge. The bench reprograms the divisor only between frames, after the event bit is seen. Its PHY responder drives turnaround and read data strictly on the MDC falling edges of the frame it is answering.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_W    = 32;
  localparam int DATA_W     = 16;
  localparam int RD_OP_BIT  = 29;  // opcode msb: 1 on every read opcode
  localparam int TA_IDX     = 14;  // frame bit index of first turnaround bit
  localparam int DATA_IDX   = 16;  // frame bit index of first data bit
  localparam int REG_CTRL   = 0;
  localparam int REG_DATA   = 1;
  localparam int REG_EVT    = 2;
  localparam int EVT_BIT    = 0;
  localparam int BUSY_BIT   = 1;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W  = 8,
  parameter int HOLD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              mdc_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              upd_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_eff, hold_ext, hold_lim, hold_eff;
  logic [CNT_W-1:0] half, last, cnt_q;
  logic             mdc_q;

  always_comb begin
    div_eff  = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
    hold_ext = DIV_W'(hold_i);
    hold_lim = div_eff - DIV_W'(2);
    hold_eff = (hold_ext > hold_lim) ? hold_lim : hold_ext;
    half     = {1'b0, div_eff};
    last     = (half << 1) - CNT_W'(1);
  end

  assign rise_o = run_i && (cnt_q == half - CNT_W'(1));
  assign fall_o = run_i && (cnt_q == last);
  assign upd_o  = run_i && (cnt_q == {1'b0, hold_eff});
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CNT_W'(1);
      if (rise_o)      mdc_q <= 1'b1;
      else if (fall_o) mdc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               upd_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               rd_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam int BITS  = PRE_LEN + FRAME_W;
  localparam int IDX_W = $clog2(BITS);

  logic               busy_q, rd_q, out_q, oe_q;
  logic [IDX_W-1:0]   idx_q, fidx;
  logic [FRAME_W-1:0] sr_q;
  logic [DATA_W-1:0]  rsr_q;
  logic               in_frame, last_bit;

  assign in_frame = idx_q >= IDX_W'(PRE_LEN);
  assign fidx     = idx_q - IDX_W'(PRE_LEN);
  assign last_bit = idx_q == IDX_W'(BITS - 1);

  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last_bit;
  assign rd_o      = rd_q;
  assign rd_data_o = rsr_q;
  assign mdio_o    = out_q;
  assign mdio_oe_o = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '0;
      rsr_q  <= '0;
      out_q  <= 1'b1;
      oe_q   <= 1'b0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sr_q   <= frame_i;
      rd_q   <= frame_i[RD_OP_BIT];
    end else if (busy_q) begin
      if (upd_i) begin
        if (!in_frame) begin
          out_q <= 1'b1;
          oe_q  <= 1'b1;
        end else begin
          out_q <= sr_q[FRAME_W-1];
          sr_q  <= sr_q << 1;
          oe_q  <= !(rd_q && (fidx >= IDX_W'(TA_IDX)));
        end
      end
      if (rise_i && rd_q && in_frame && (fidx >= IDX_W'(DATA_IDX)))
        rsr_q <= {rsr_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          out_q  <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int HOLD_W   = 3,
  parameter int DEF_DIV  = 63,
  parameter int DEF_HOLD = 5,
  parameter int ADDR_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FRAME_W-1:0] wdata_i,
  output logic [FRAME_W-1:0] rdata_o,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  rd_data_i,
  output logic               start_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [FRAME_W-1:0] frame_q_o,
  output logic               evt_o,
  output logic [DIV_W-1:0]   div_o,
  output logic [HOLD_W-1:0]  hold_o
);
  logic [DIV_W-1:0]   div_q;
  logic [HOLD_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame_q;
  logic               evt_q, wr, sel_ctrl, sel_data, sel_evt;

  assign wr       = req_i && we_i;
  assign sel_ctrl = addr_i == ADDR_W'(REG_CTRL);
  assign sel_data = addr_i == ADDR_W'(REG_DATA);
  assign sel_evt  = addr_i == ADDR_W'(REG_EVT);
  assign start_o  = wr && sel_data && !busy_i;
  assign frame_o  = wdata_i;
  assign frame_q_o = frame_q;
  assign evt_o    = evt_q;
  assign div_o    = div_q;
  assign hold_o   = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= DIV_W'(DEF_DIV);
      hold_q  <= HOLD_W'(DEF_HOLD);
      frame_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      if (wr && sel_ctrl) begin
        div_q  <= wdata_i[DIV_W-1:0];
        hold_q <= wdata_i[DIV_W +: HOLD_W];
      end
      if (start_o) frame_q <= wdata_i;
      else if (done_i && rd_i) frame_q[DATA_W-1:0] <= rd_data_i;
      if (done_i) evt_q <= 1'b1;  // set wins over clear
      else if (wr && sel_evt && wdata_i[EVT_BIT]) evt_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[DIV_W-1:0]      = div_q;
      rdata_o[DIV_W +: HOLD_W] = hold_q;
    end else if (sel_data) begin
      rdata_o = frame_q;
    end else if (sel_evt) begin
      rdata_o[EVT_BIT]  = evt_q;
      rdata_o[BUSY_BIT] = busy_i;
    end
  end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int HOLD_W   = 3,
  parameter int DEF_DIV  = 63,
  parameter int DEF_HOLD = 5,
  parameter int PRE_LEN  = 32,
  parameter int ADDR_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic               busy, done, rd, start, evt;
  logic               rise, fall, upd;
  logic [DATA_W-1:0]  rd_data;
  logic [FRAME_W-1:0] frame, frame_q;
  logic [DIV_W-1:0]   div;
  logic [HOLD_W-1:0]  hold;

  mdio_regs #(
    .DIV_W(DIV_W), .HOLD_W(HOLD_W), .DEF_DIV(DEF_DIV),
    .DEF_HOLD(DEF_HOLD), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .busy_i(busy), .done_i(done), .rd_i(rd), .rd_data_i(rd_data),
    .start_o(start), .frame_o(frame), .frame_q_o(frame_q), .evt_o(evt),
    .div_o(div), .hold_o(hold)
  );

  mdio_clkgen #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .div_i(div),
    .hold_i(hold), .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall), .upd_o(upd)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .frame_i(frame),
    .rise_i(rise), .fall_i(fall), .upd_i(upd), .mdio_i(mdio_i),
    .busy_o(busy), .done_o(done), .rd_o(rd), .rd_data_o(rd_data),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
module mdio_master_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wbit0_i,
  input logic              busy_i,
  input logic              evt_i,
  input logic [31:0]       frame_i,
  input logic              mdc_i,
  input logic              dout_i,
  input logic              oe_i
);
  logic clr, launch;
  assign clr    = req_i && we_i && (addr_i == ADDR_W'(2)) && wbit0_i;
  assign launch = req_i && we_i && (addr_i == ADDR_W'(1)) && !busy_i;

  p_mdc_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mdc_i);
  p_mdio_stable_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(dout_i) && $stable(oe_i)));
  p_oe_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);
  p_evt_on_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> evt_i);
  p_evt_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clr) |=> evt_i);
  p_busy_launch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_i);
  p_frame_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(frame_i));
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wbit0_i(wdata_i[0]), .busy_i(busy), .evt_i(evt),
  .frame_i(frame_q), .mdc_i(mdc_o), .dout_i(mdio_o), .oe_i(mdio_oe_o)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  // PHY responder state
  int          pe = 0, ones = 0, ta_err = 0, ovl = 0, nx = 0;
  logic [31:0] cap = '0;
  logic        rdf = 1'b0, phy_oe = 1'b0, phy_d = 1'b1;
  logic [15:0] resp = '0;

  // timing monitor
  int          cyc = 0, fall_cyc = 0, rise_cyc = 0, meas_hold = 0, meas_per = 0;
  logic        prev_o = 1'b1, prev_mdc = 1'b0;

  always #4 clk = ~clk;

  mdio_master u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_d : 1'b1);

  always @(posedge mdc) begin
    pe++;
    if (pe <= 32) begin
      if (mdio_i) ones++;
    end else begin
      cap = {cap[30:0], mdio_i};
      if (pe == 35) rdf = mdio_i;
      if (rdf && pe >= 47 && mdio_oe) ta_err++;
    end
  end

  always @(negedge mdc) begin
    nx = pe - 32;
    if (rdf && nx == 15) begin
      phy_oe = 1'b1;
      phy_d  = 1'b0;
    end else if (rdf && nx >= 16 && nx <= 31) begin
      phy_d = resp[31-nx];
    end else if (nx >= 32) begin
      phy_oe = 1'b0;
    end
  end

  always @(posedge clk) begin
    #1;
    cyc++;
    if (prev_mdc && !mdc) fall_cyc = cyc;
    if (!prev_mdc && mdc) begin
      meas_per = cyc - rise_cyc;
      rise_cyc = cyc;
    end
    if (mdio_oe && (mdio_o !== prev_o)) meas_hold = cyc - fall_cyc;
    if (mdio_oe && phy_oe) ovl++;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic phy_reset();
    pe = 0; ones = 0; cap = '0; rdf = 1'b0; phy_oe = 1'b0;
    ta_err = 0; ovl = 0;
  endtask

  task automatic wait_evt(input string tag);
    logic [31:0] v;
    int n;
    v = '0; n = 0;
    while (!v[0] && n < 20000) begin
      bus_rd(2'd2, v);
      n++;
    end
    chk(tag, {31'b0, v[0]}, 32'd1);
  endtask

  task automatic launch(input logic [31:0] f);
    phy_reset();
    bus_wr(2'd1, f);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(2'd0, v);  chk("R1 ctrl default", v, 32'h0000_053F);
    bus_rd(2'd2, v);  chk("R1 event default", v, 32'h0);
    chk("R1 mdc low", {31'b0, mdc}, 32'h0);
    chk("R1 mdio released", {31'b0, mdio_oe}, 32'h0);
  endtask

  task automatic t_c22_write();
    logic [31:0] v, f;
    f = {2'b01, 2'b01, 5'd3, 5'd9, 2'b10, 16'hA55A};
    bus_wr(2'd0, 32'h0000_0104);  // div 4, hold 1
    launch(f);
    repeat (3) @(negedge clk);
    bus_rd(2'd2, v);  chk("R8 busy during frame", v, 32'h2);
    wait_evt("R7 c22 write completion");
    chk("R2 preamble ones", ones, 32);
    chk("R2 edge count", pe, 64);
    chk("R2 R10 c22 write frame bits", cap, f);
    chk("R5 no contention on write", ovl, 0);
    chk("R3 mdc period div4", meas_per, 8);
    chk("R4 hold delay hold1", meas_hold, 2);
    bus_rd(2'd2, v);  chk("R8 busy cleared event set", v, 32'h1);
    bus_rd(2'd1, v);  chk("R6 write frame data unchanged", v, f);
    chk("R3 mdc low after frame", {31'b0, mdc}, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    bus_wr(2'd2, 32'h0);
    bus_rd(2'd2, v);  chk("R7 write zero keeps event", v, 32'h1);
    bus_wr(2'd2, 32'h1);
    bus_rd(2'd2, v);  chk("R7 write one clears event", v, 32'h0);
  endtask

  task automatic t_c22_read();
    logic [31:0] v, f;
    f = {2'b01, 2'b10, 5'd1, 5'd2, 2'b10, 16'h0000};
    resp = 16'hBEEF;
    launch(f);
    wait_evt("R7 c22 read completion");
    bus_rd(2'd1, v);  chk("R6 c22 read data", v, {f[31:16], 16'hBEEF});
    chk("R10 c22 read header bits", {18'b0, cap[31:18]}, {18'b0, f[31:18]});
    chk("R5 turnaround line pulled then phy zero", {30'b0, cap[17:16]}, 32'h2);
    chk("R5 master released after turnaround", ta_err, 0);
    chk("R5 no contention on read", ovl, 0);
    bus_wr(2'd2, 32'h1);
  endtask

  task automatic t_c45();
    logic [31:0] v, fa, fr, fw;
    fa = {2'b00, 2'b00, 5'd5, 5'd1, 2'b10, 16'h1234};
    fr = {2'b00, 2'b11, 5'd5, 5'd1, 2'b10, 16'h0000};
    fw = {2'b00, 2'b01, 5'd5, 5'd1, 2'b10, 16'hC3C3};
    bus_wr(2'd0, 32'h0000_0700);  // div 0 -> 2, hold 7 -> 0
    launch(fa);
    wait_evt("R7 c45 address completion");
    chk("R10 c45 address frame bits", cap, fa);
    chk("R3 mdc period clamped", meas_per, 4);
    chk("R4 hold clamped", meas_hold, 1);
    bus_wr(2'd2, 32'h1);
    resp = 16'h0F0F;
    launch(fr);
    wait_evt("R7 c45 read completion");
    bus_rd(2'd1, v);  chk("R10 R6 c45 read data", v, {fr[31:16], 16'h0F0F});
    chk("R5 c45 read release", ta_err, 0);
    bus_wr(2'd2, 32'h1);
    launch(fw);
    wait_evt("R7 c45 write completion");
    chk("R10 c45 write frame bits", cap, fw);
    bus_wr(2'd2, 32'h1);
  endtask

  task automatic t_ignore();
    logic [31:0] v, fa, fb;
    fa = {2'b01, 2'b01, 5'd7, 5'd4, 2'b10, 16'h5A5A};
    fb = {2'b01, 2'b01, 5'd2, 5'd8, 2'b10, 16'hFFFF};
    bus_wr(2'd0, 32'h0000_0104);
    launch(fa);
    repeat (20) @(negedge clk);
    bus_wr(2'd1, fb);
    bus_rd(2'd1, v);  chk("R9 data register kept while busy", v, fa);
    wait_evt("R7 ignore test completion");
    chk("R9 running frame unchanged", cap, fa);
    repeat (300) @(negedge clk);
    chk("R9 no extra frame", pe, 64);
    bus_wr(2'd2, 32'h1);
  endtask

  task automatic t_slow();
    logic [31:0] f;
    f = {2'b01, 2'b01, 5'd0, 5'd0, 2'b10, 16'h00FF};
    bus_wr(2'd0, 32'h0000_053F);
    launch(f);
    wait_evt("R7 slow completion");
    chk("R3 mdc period div63", meas_per, 126);
    chk("R4 hold delay hold5", meas_hold, 6);
    chk("R2 slow frame bits", cap, f);
    bus_wr(2'd2, 32'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_c22_write();
    t_w1c();
    t_c22_read();
    t_c45();
    t_ignore();
    t_slow();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule